// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This host-side sequencer drives a raw 8-bit NAND flash bus to erase one block and report the outcome. A caller presents a plane number and a block number with a one-cycle request. The sequencer writes the erase-setup command, two row-address bytes that carry the block's first page, and the erase-confirm command, each framed by a write-enable strobe. It then waits for the device to finish and reads the status byte to find out how the erase ended.

The wait takes one of two forms, chosen per request. In pin mode the sequencer watches the shared ready line and reads status once when that line goes high. In polling mode it sends the status command right after the confirm and keeps reading the status byte until the ready bit is set. Polling is the mode to use when several devices share one wired ready line. After a readable status, the sequencer sends the read command so that later data reads do not return status. A cycle-count limit guards the wait. The caller gets a one-cycle done pulse carrying one of four result codes. Setup, strobe width and hold are all parameters counted in clock cycles.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, chip enable, write enable and read enable are high (inactive), command and address latch enables are low, and busy and done are low.
- R2: A request is accepted only while busy is low. A request raised during an operation has no effect on the bytes sent or on the result.
- R3: An operation writes 60h with the command latch high. It then writes the row low byte and the row high byte with the address latch high, and then D0h with the command latch high. The 16-bit row is {block, plane, six zero page bits}, and the first address byte is row bits 7:0.
- R4: The command latch, the address latch and the data bus are stable for at least T_SETUP cycles before write enable falls and for at least T_HOLD cycles after it rises. Write enable stays low for exactly T_PULSE cycles.
- R5: In pin mode (poll_mode = 0), the sequencer waits for the ready input to go high. It then writes 70h once and performs exactly one status read.
- R6: In polling mode, 70h follows D0h directly. Status reads then repeat without a second 70h until status bit 6 (1 = ready) is set. A status read returns the byte on the bus while read enable is low.
- R7: The result code is 2 (write-protected) when status bit 7 is 0. Otherwise it is 1 (fail) when bit 0 is 1, and 0 (pass) when bit 0 is 0. Bits 1 to 5 do not affect the result.
- R8: If the device is not ready within TIMEOUT_CYC cycles of the wait starting, the result is 3 (timeout). No command is written after that point.
- R9: After a completed status read, 00h is written with the command latch high before done is raised.
- R10: Busy is high from the cycle after acceptance up to and including the done cycle. Done lasts exactly one cycle, and the result is valid while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start an erase (taken only when idle) |
| req_plane | input | PLANE_W | Plane number |
| req_block | input | BLOCK_W | Block number |
| poll_mode | input | 1 | 1 = poll status byte, 0 = wait on ready line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 pass, 1 fail, 2 protected, 3 timeout |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable strobe, active low |
| nf_re_n | output | 1 | Read enable strobe, active low |
| nf_dq_out | output | 8 | Byte driven onto the bus |
| nf_dq_oe | output | 1 | Bus drive enable |
| nf_dq_in | input | 8 | Byte read from the bus |
| nf_rdy | input | 1 | Ready/busy line, 1 = ready |

## Verification
The bench pairs a behavioural device model with a table of erases. The table mixes both wait modes, both plane values, the lowest and highest block numbers, and pass, fail and protected outcomes. Some rows set nonzero don't-care status bits and some set a busy time beyond the limit. Long busy times in polling mode separate repeated status reads from a single read. The protected-with-fail rows show that the protect bit takes priority. The junk rows show that bits 1 to 5 are ignored. The over-limit rows in each mode show where the sequence stops. A bus monitor measures setup, hold and strobe width on every write. A request raised mid-operation shows that only the first request shapes the sequence.

// File: rtl/nes_pkg.sv
package nes_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_SETUP,
        ST_W_ADR_LO,
        ST_W_ADR_HI,
        ST_W_CONFIRM,
        ST_WAIT_WB,
        ST_WAIT_RDY,
        ST_W_STATUS,
        ST_RD_STATUS,
        ST_W_READ00,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } strobe_phase_t;

    typedef enum logic [1:0] {
        RES_PASS    = 2'd0,
        RES_FAIL    = 2'd1,
        RES_PROT    = 2'd2,
        RES_TIMEOUT = 2'd3
    } erase_res_t;

    localparam logic [7:0] CMD_ERASE_SETUP   = 8'h60;
    localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_STATUS        = 8'h70;
    localparam logic [7:0] CMD_READ          = 8'h00;

    localparam int ST_BIT_FAIL  = 0;
    localparam int ST_BIT_READY = 6;
    localparam int ST_BIT_WPN   = 7;

endpackage

// File: rtl/nes_bus_strobe.sv
module nes_bus_strobe
    import nes_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 2,
    parameter int T_HOLD  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd,
    output logic we_n,
    output logic re_n,
    output logic cap,
    output logic fin
);
    localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                              : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
    localparam int CW = (TMAX < 2) ? 1 : $clog2(TMAX);

    typedef struct packed {
        strobe_phase_t  ph;
        logic           rd;
        logic [CW-1:0]  cnt;
    } strobe_t;

    strobe_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        cap = 1'b0;
        fin = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph  = PH_SETUP;
                    s_d.rd  = rd;
                    s_d.cnt = CW'(T_SETUP - 1);
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_PULSE;
                    s_d.cnt = CW'(T_PULSE - 1);
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            PH_PULSE: begin
                if (s_q.cnt == '0) begin
                    cap     = s_q.rd;
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = CW'(T_HOLD - 1);
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            default: begin
                if (s_q.cnt == '0) begin
                    fin    = 1'b1;
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign we_n = !((s_q.ph == PH_PULSE) && !s_q.rd);
    assign re_n = !((s_q.ph == PH_PULSE) &&  s_q.rd);

endmodule

// File: rtl/nes_wait_timer.sv
module nes_wait_timer #(
    parameter int LIMIT = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == TW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (run && !expired) cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/nes_status_decode.sv
module nes_status_decode
    import nes_pkg::*;
(
    input  logic [7:0]  status,
    output logic        ready,
    output erase_res_t  res
);
    always_comb begin
        ready = status[ST_BIT_READY];
        if (!status[ST_BIT_WPN])      res = RES_PROT;
        else if (status[ST_BIT_FAIL]) res = RES_FAIL;
        else                          res = RES_PASS;
    end
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nes_pkg::*;
#(
    parameter int PLANE_W     = 1,
    parameter int BLOCK_W     = 9,
    parameter int PAGE_W      = 6,
    parameter int T_SETUP     = 2,
    parameter int T_PULSE     = 2,
    parameter int T_HOLD      = 1,
    parameter int T_WB        = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 200000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PLANE_W-1:0] req_plane,
    input  logic [BLOCK_W-1:0] req_block,
    input  logic               poll_mode,
    output logic               busy,
    output logic               done,
    output logic [1:0]         result,
    output logic               nf_ce_n,
    output logic               nf_cle,
    output logic               nf_ale,
    output logic               nf_we_n,
    output logic               nf_re_n,
    output logic [7:0]         nf_dq_out,
    output logic               nf_dq_oe,
    input  logic [7:0]         nf_dq_in,
    input  logic               nf_rdy
);
    localparam int ROW_W = 16;
    localparam int WBW   = (T_WB < 2) ? 1 : $clog2(T_WB);

    typedef struct packed {
        seq_state_t             st;
        logic                   go;
        logic                   rd;
        logic                   cle;
        logic                   ale;
        logic [7:0]             dq;
        logic [ROW_W-1:0]       row;
        logic                   poll;
        logic [7:0]             stat;
        erase_res_t             res;
        logic [WBW-1:0]         wb;
        logic [SYNC_STAGES-1:0] rsync;
    } seq_t;

    seq_t       r_d, r_q;
    logic       stb_cap, stb_fin;
    logic       tmr_clr, tmr_run, tmr_exp;
    logic       st_ready;
    erase_res_t st_res;
    logic       rdy_s;

    assign rdy_s = r_q.rsync[SYNC_STAGES-1];

    nes_bus_strobe #(
        .T_SETUP (T_SETUP),
        .T_PULSE (T_PULSE),
        .T_HOLD  (T_HOLD)
    ) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .start (r_q.go),
        .rd    (r_q.rd),
        .we_n  (nf_we_n),
        .re_n  (nf_re_n),
        .cap   (stb_cap),
        .fin   (stb_fin)
    );

    nes_wait_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    nes_status_decode u_decode (
        .status (r_q.stat),
        .ready  (st_ready),
        .res    (st_res)
    );

    assign tmr_clr = (r_q.st == ST_IDLE);
    assign tmr_run = (r_q.st == ST_WAIT_WB) || (r_q.st == ST_WAIT_RDY) ||
                     (r_q.poll && ((r_q.st == ST_W_STATUS) || (r_q.st == ST_RD_STATUS)));

    always_comb begin
        r_d       = r_q;
        r_d.go    = 1'b0;
        r_d.rsync = {r_q.rsync[SYNC_STAGES-2:0], nf_rdy};
        if (stb_cap) r_d.stat = nf_dq_in;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.row  = ROW_W'({req_block, req_plane, {PAGE_W{1'b0}}});
                    r_d.poll = poll_mode;
                    r_d.st   = ST_W_SETUP;
                    r_d.go   = 1'b1;
                    r_d.rd   = 1'b0;
                    r_d.cle  = 1'b1;
                    r_d.ale  = 1'b0;
                    r_d.dq   = CMD_ERASE_SETUP;
                end
            end
            ST_W_SETUP: begin
                if (stb_fin) begin
                    r_d.st  = ST_W_ADR_LO;
                    r_d.go  = 1'b1;
                    r_d.cle = 1'b0;
                    r_d.ale = 1'b1;
                    r_d.dq  = r_q.row[7:0];
                end
            end
            ST_W_ADR_LO: begin
                if (stb_fin) begin
                    r_d.st = ST_W_ADR_HI;
                    r_d.go = 1'b1;
                    r_d.dq = r_q.row[15:8];
                end
            end
            ST_W_ADR_HI: begin
                if (stb_fin) begin
                    r_d.st  = ST_W_CONFIRM;
                    r_d.go  = 1'b1;
                    r_d.cle = 1'b1;
                    r_d.ale = 1'b0;
                    r_d.dq  = CMD_ERASE_CONFIRM;
                end
            end
            ST_W_CONFIRM: begin
                if (stb_fin) begin
                    if (r_q.poll) begin
                        r_d.st = ST_W_STATUS;
                        r_d.go = 1'b1;
                        r_d.dq = CMD_STATUS;
                    end else begin
                        r_d.st  = ST_WAIT_WB;
                        r_d.cle = 1'b0;
                        r_d.dq  = 8'h00;
                        r_d.wb  = WBW'(T_WB - 1);
                    end
                end
            end
            ST_WAIT_WB: begin
                if (r_q.wb == '0) r_d.st = ST_WAIT_RDY;
                else              r_d.wb = r_q.wb - WBW'(1);
            end
            ST_WAIT_RDY: begin
                if (rdy_s) begin
                    r_d.st  = ST_W_STATUS;
                    r_d.go  = 1'b1;
                    r_d.cle = 1'b1;
                    r_d.dq  = CMD_STATUS;
                end else if (tmr_exp) begin
                    r_d.st  = ST_DONE;
                    r_d.res = RES_TIMEOUT;
                end
            end
            ST_W_STATUS: begin
                if (stb_fin) begin
                    r_d.st  = ST_RD_STATUS;
                    r_d.go  = 1'b1;
                    r_d.rd  = 1'b1;
                    r_d.cle = 1'b0;
                    r_d.dq  = 8'h00;
                end
            end
            ST_RD_STATUS: begin
                if (stb_fin) begin
                    if (st_ready) begin
                        r_d.st  = ST_W_READ00;
                        r_d.go  = 1'b1;
                        r_d.rd  = 1'b0;
                        r_d.cle = 1'b1;
                        r_d.dq  = CMD_READ;
                        r_d.res = st_res;
                    end else if (tmr_exp) begin
                        r_d.st  = ST_DONE;
                        r_d.rd  = 1'b0;
                        r_d.res = RES_TIMEOUT;
                    end else begin
                        r_d.go = 1'b1;
                    end
                end
            end
            ST_W_READ00: begin
                if (stb_fin) begin
                    r_d.st  = ST_DONE;
                    r_d.cle = 1'b0;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.cle = 1'b0;
                r_d.ale = 1'b0;
                r_d.rd  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_DONE);
    assign result    = r_q.res;
    assign nf_ce_n   = !busy;
    assign nf_cle    = r_q.cle;
    assign nf_ale    = r_q.ale;
    assign nf_dq_out = r_q.dq;
    assign nf_dq_oe  = busy && !r_q.rd;

endmodule

// File: rtl/nand_erase_seq_chk.sv
module nand_erase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       nf_ce_n,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic [7:0] nf_dq_out,
    input logic       nf_dq_oe
);
    // R3: command and address latches never both high
    a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    // R4: latches and data steady while write strobe is low
    a_r4_lines_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_cle) && $stable(nf_ale) && $stable(nf_dq_out)));

    // R4: never write and read strobes at once
    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    // R6: bus released while read strobe is low
    a_r6_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_dq_oe);

    // R10: done is one cycle wide and within busy
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R1: quiet bus when idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nf_ce_n && nf_we_n && nf_re_n));
endmodule

bind nand_erase_seq nand_erase_seq_chk u_chk (.*);

// File: tb/nand_erase_seq_tb.sv
module nand_erase_seq_tb;
    localparam int T_SETUP = 2;
    localparam int T_PULSE = 2;
    localparam int T_HOLD  = 1;
    localparam int T_WB    = 4;
    localparam int TMO     = 400;
    localparam int NVEC    = 8;

    // [30] poll [29] plane [28:20] block [19:8] busy [7] wp [6] fail [5:2] junk [1:0] expected
    localparam logic [30:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b0, 9'd5,   12'd30,  1'b0, 1'b0, 4'h0, 2'd0},
        {1'b0, 1'b1, 9'd511, 12'd50,  1'b0, 1'b1, 4'h0, 2'd1},
        {1'b1, 1'b0, 9'd163, 12'd80,  1'b0, 1'b0, 4'hF, 2'd0},
        {1'b1, 1'b1, 9'd256, 12'd90,  1'b0, 1'b1, 4'hA, 2'd1},
        {1'b1, 1'b0, 9'd7,   12'd5,   1'b1, 1'b0, 4'h0, 2'd2},
        {1'b0, 1'b1, 9'd3,   12'd5,   1'b1, 1'b1, 4'h5, 2'd2},
        {1'b0, 1'b0, 9'd9,   12'd900, 1'b0, 1'b0, 4'h0, 2'd3},
        {1'b1, 1'b1, 9'd9,   12'd900, 1'b0, 1'b0, 4'h0, 2'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [0:0] req_plane;
    logic [8:0] req_block;
    logic       poll_mode;
    logic       busy, done;
    logic [1:0] result;
    logic       nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_rdy;
    logic [7:0] nf_dq_out, nf_dq_in;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nand_erase_seq #(
        .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
        .T_WB(T_WB), .TIMEOUT_CYC(TMO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_plane(req_plane),
        .req_block(req_block), .poll_mode(poll_mode), .busy(busy), .done(done),
        .result(result), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
        .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rdy(nf_rdy)
    );

    // ---------------- device model ----------------
    int         m_busy = 0;
    logic       m_wp = 1'b0, m_fail = 1'b0;
    logic [3:0] m_junk = 4'h0;
    int         busy_cnt = 0;
    logic       we_prev = 1'b1, re_prev = 1'b1;
    logic [7:0] log_b [0:255];
    logic [1:0] log_k [0:255];
    int         n_log = 0, n_reads = 0;
    logic       m_rdy;
    logic [7:0] m_status;

    assign m_rdy    = (busy_cnt == 0);
    assign nf_rdy   = m_rdy;
    assign m_status = {~m_wp, m_rdy, m_rdy, m_junk, m_rdy ? m_fail : 1'b1};
    assign nf_dq_in = nf_re_n ? 8'h00 : m_status;

    always @(posedge clk) begin
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (!we_prev && nf_we_n) begin
            log_b[n_log[7:0]] <= nf_dq_out;
            log_k[n_log[7:0]] <= {nf_ale, nf_cle};
            n_log <= n_log + 1;
            if (nf_cle && nf_dq_out == 8'hD0) busy_cnt <= m_busy;
        end
        if (!re_prev && nf_re_n) n_reads <= n_reads + 1;
        we_prev <= nf_we_n;
        re_prev <= nf_re_n;
    end

    // ---------------- bus timing monitor ----------------
    int   viol = 0;
    int   since_line = 1000, since_rise = 1000, low_cnt = 0;
    logic [9:0] lines_prev = '0;
    logic mon_we_prev = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            since_line = since_line + 1;
            since_rise = since_rise + 1;
            if ({nf_cle, nf_ale, nf_dq_out} != lines_prev) begin
                if (since_rise < T_HOLD) viol = viol + 1;
                since_line = 0;
            end
            if (!mon_we_prev && nf_we_n) begin
                if (low_cnt != T_PULSE) viol = viol + 1;
                since_rise = 0;
            end
            if (mon_we_prev && !nf_we_n) begin
                if (since_line < T_SETUP) viol = viol + 1;
                low_cnt = 1;
            end else if (!nf_we_n) begin
                low_cnt = low_cnt + 1;
            end
            lines_prev  = {nf_cle, nf_ale, nf_dq_out};
            mon_we_prev = nf_we_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic run_op(input logic pm, input logic pl, input logic [8:0] blk,
                          input int bsy, input logic wp, input logic fl,
                          input logic [3:0] junk, input logic [1:0] expr,
                          input bit intrude);
        int base_log, base_reads, base_viol, nexp, got;
        logic [15:0] row;
        logic [7:0] eb [0:5];
        logic [1:0] ek [0:5];
        bit seen, seq_ok;
        row = {blk, pl, 6'd0};
        m_busy = bsy; m_wp = wp; m_fail = fl; m_junk = junk;
        base_log = n_log; base_reads = n_reads; base_viol = viol;
        @(negedge clk);
        req_valid = 1'b1; poll_mode = pm; req_plane = pl; req_block = blk;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (intrude && i == 5) begin
                req_valid = 1'b1; req_block = 9'd77; poll_mode = ~pm;
            end else begin
                req_valid = 1'b0;
            end
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(seen, "R10 done seen", seen, 1);
        if (!seen) return;
        chk(result == expr, "R7/R8 result code", result, expr);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 done one cycle", {done, busy}, 0);
        eb[0] = 8'h60;      ek[0] = 2'b01;
        eb[1] = row[7:0];   ek[1] = 2'b10;
        eb[2] = row[15:8];  ek[2] = 2'b10;
        eb[3] = 8'hD0;      ek[3] = 2'b01;
        eb[4] = 8'h70;      ek[4] = 2'b01;
        eb[5] = 8'h00;      ek[5] = 2'b01;
        nexp = (expr != 2'd3) ? 6 : (pm ? 5 : 4);
        got = n_log - base_log;
        seq_ok = (got == nexp);
        for (int j = 0; j < 6; j++)
            if (seq_ok && j < nexp)
                if (log_b[(base_log + j) % 256] != eb[j] || log_k[(base_log + j) % 256] != ek[j])
                    seq_ok = 1'b0;
        chk(seq_ok, intrude ? "R2 ignored request / R3 sequence" : "R3/R9 command sequence", got, nexp);
        if (expr != 2'd3 && !pm)
            chk(n_reads - base_reads == 1, "R5 one status read", n_reads - base_reads, 1);
        if (expr != 2'd3 && pm && bsy > 60)
            chk(n_reads - base_reads > 1, "R6 repeated status reads", n_reads - base_reads, 2);
        chk(viol == base_viol, "R4 setup/hold/width", viol - base_viol, 0);
        for (int k = 0; k < 2000 && !m_rdy; k++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_plane = '0; req_block = '0; poll_mode = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes idle", {nf_ce_n, nf_we_n, nf_re_n}, 7);
        chk(!nf_cle && !nf_ale && !busy && !done, "R1 latches/busy/done low",
            {nf_cle, nf_ale, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int v = 0; v < NVEC; v++) begin
            logic [30:0] e;
            e = VEC[v];
            run_op(e[30], e[29], e[28:20], int'(e[19:8]), e[7], e[6], e[5:2], e[1:0], 1'b0);
        end
        // R2: request raised mid-operation is ignored
        run_op(1'b0, 1'b1, 9'd300, 20, 1'b0, 1'b0, 4'h0, 2'd0, 1'b1);
        // R7: bits 1..5 ignored, pass in polling mode with full junk
        run_op(1'b1, 1'b0, 9'd0, 10, 1'b0, 1'b0, 4'hF, 2'd0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule